// File: doc/BRIEF.md
# Error Record Control and Signaling

This block keeps the control word of one error-record node and turns the error events that the node detects into interrupt and response signals. Software reads and writes the control word through a plain register port. Each control can be left out, built as one control for both directions, or built as a pair of read and write controls. A two-bit capability code per feature, fixed by a parameter, makes that choice. Controls that are left out read as zero and ignore writes.

Each error event arrives as a one-cycle strobe. The strobe carries a class (corrected, deferred, uncorrected or critical), a direction (read or write) and a flag that marks the error as one that cannot be deferred. A separate one-cycle pulse reports that a corrected-error counter has overflowed. From these inputs the block raises three level interrupts: fault handling, error recovery and critical. Each interrupt stays high until it is cleared. The block also drives an abort flag in the same cycle as the event, so the transaction response can report the error in-band.

There are two resets. A cold reset loads the control word from parameters. An error-recovery reset clears the pending interrupts and leaves the control word unchanged.

Top module: `errctl_sig`

## Requirements
- R1: Only implemented control bits keep written values; bits 1, 12 and 63:14, and bits of features whose code is neither 2'b10 nor 2'b11, read 0. Bit positions: 0 report, 2 uncorrected-recovery (read), 3 fault (read), 4 in-band abort (read), 5/6/7 write versions of bits 2/3/4, 8 corrected-fault (read), 9 its write version, 10 deferred-recovery (read), 11 its write version, 13 critical. The critical bit exists only with code 2'b10.
- R2: A cold reset (rst_n low) loads bit 0 from REPORT_RST and every other implemented bit from CTRL_RST. It also clears all interrupts and the abort flag.
- R3: While the report bit is implemented and reads 0, no event or overflow asserts any interrupt or abort.
- R4: Code 2'b10 makes the low bit govern both directions. Code 2'b11 makes the low bit govern reads (evt_write=0) and the write bit govern writes (evt_write=1).
- R5: The fault enable for the event's direction raises irq_fault for every deferred or uncorrected event.
- R6: Corrected-error fault signaling uses the corrected-fault enable. If that control is absent, it uses the fault enable instead. With HAS_COUNTERS=1, an ovf_valid pulse in direction ovf_write triggers it and corrected events do not. With HAS_COUNTERS=0, every corrected event triggers it.
- R7: irq_recov rises for uncorrected events under the uncorrected-recovery enable, and for deferred events under the deferred-recovery enable.
- R8: abort_o is high in the event cycle only for an uncorrected event flagged non-deferrable (evt_nodefer=1) whose in-band enable is set. evt_class encoding: 0 corrected, 1 deferred, 2 uncorrected, 3 critical.
- R9: A critical event raises irq_crit when the critical bit is set. Otherwise it is handled as an uncorrected, non-deferrable event.
- R10: An interrupt rises at the clock edge that samples its trigger and holds until an irq_clr pulse. A trigger in the same cycle as the clear wins.
- R11: rec_rst_n low clears all interrupts and leaves the control word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, synchronous, active low |
| rec_rst_n | input | 1 | Error-recovery reset, synchronous, active low |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | REG_W | Control word write data |
| reg_rdata | output | REG_W | Control word read data |
| evt_valid | input | 1 | Error event strobe |
| evt_class | input | 2 | Event class |
| evt_write | input | 1 | Event came from a write |
| evt_nodefer | input | 1 | Error cannot be deferred |
| ovf_valid | input | 1 | Corrected-error counter overflow pulse |
| ovf_write | input | 1 | Overflow direction is write |
| irq_clr | input | 1 | Clears all pending interrupts |
| irq_fault | output | 1 | Fault-handling interrupt level |
| irq_recov | output | 1 | Error-recovery interrupt level |
| irq_crit | output | 1 | Critical interrupt level |
| abort_o | output | 1 | In-band abort for the current event |

## Verification
abort_o is combinational from the event strobe and the stored control word. It is therefore due in the cycle of the strobe. The bench samples it one time step after it drives the strobe at the falling edge. Each interrupt is registered and appears after the next rising edge, so the bench samples it at the following falling edge. A control write also lands on one rising edge. The bench therefore writes the control word and pulses the clear together one full cycle before every event. This way each vector starts from a known control word with no interrupt pending.

// File: rtl/errctl_pkg.sv
package errctl_pkg;
  localparam int CTRL_W = 14;
  localparam int NFEAT  = 5;

  localparam logic [1:0] CAP_SHARED = 2'b10;
  localparam logic [1:0] CAP_SPLIT  = 2'b11;

  localparam logic [1:0] CLS_CORR = 2'd0;
  localparam logic [1:0] CLS_DEF  = 2'd1;
  localparam logic [1:0] CLS_UNC  = 2'd2;
  localparam logic [1:0] CLS_CRIT = 2'd3;

  // feature index into the capability vector
  localparam int F_UREC   = 0;
  localparam int F_FAULT  = 1;
  localparam int F_INBAND = 2;
  localparam int F_CFAULT = 3;
  localparam int F_DREC   = 4;

  localparam int B_REPORT = 0;
  localparam int B_CRIT   = 13;

  // low (shared or read) and write bit of each feature, software-visible
  function automatic int feat_lo(input int f);
    case (f)
      F_UREC:   return 2;
      F_FAULT:  return 3;
      F_INBAND: return 4;
      F_CFAULT: return 8;
      default:  return 10;
    endcase
  endfunction

  function automatic int feat_hi(input int f);
    case (f)
      F_UREC:   return 5;
      F_FAULT:  return 6;
      F_INBAND: return 7;
      F_CFAULT: return 9;
      default:  return 11;
    endcase
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_mask(input logic [1:0] rep,
                                                  input logic [1:0] crit,
                                                  input logic [NFEAT-1:0][1:0] caps);
    logic [CTRL_W-1:0] m;
    m = '0;
    m[B_REPORT] = (rep == CAP_SHARED);
    m[B_CRIT]   = (crit == CAP_SHARED);
    for (int f = 0; f < NFEAT; f++) begin
      m[feat_lo(f)] = (caps[f] == CAP_SHARED) || (caps[f] == CAP_SPLIT);
      m[feat_hi(f)] = (caps[f] == CAP_SPLIT);
    end
    return m;
  endfunction
endpackage

// File: rtl/errctl_regs.sv
module errctl_regs #(
  parameter int                         W        = 14,
  parameter logic [W-1:0]               MASK     = '0,
  parameter logic [W-1:0]               RST_VAL  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   ctrl_q <= RST_VAL & MASK;
    else if (we)  ctrl_q <= wdata & MASK;
  end
endmodule

// File: rtl/errctl_dirsel.sv
module errctl_dirsel #(
  parameter logic [1:0] CAP = 2'b10
) (
  input  logic lo,
  input  logic hi,
  input  logic is_write,
  output logic en
);
  assign en = (CAP == errctl_pkg::CAP_SHARED) ? lo :
              (CAP == errctl_pkg::CAP_SPLIT)  ? (is_write ? hi : lo) : 1'b0;
endmodule

// File: rtl/errctl_irq_flag.sv
module errctl_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic rec_rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n || !rec_rst_n) q <= 1'b0;
    else if (set)             q <= 1'b1;
    else if (clr)             q <= 1'b0;
  end
endmodule

// File: rtl/errctl_sig.sv
module errctl_sig #(
  parameter int          REG_W        = 64,
  parameter logic [1:0]  CAP_REPORT   = 2'b10,
  parameter logic [1:0]  CAP_UREC     = 2'b11,
  parameter logic [1:0]  CAP_FAULT    = 2'b11,
  parameter logic [1:0]  CAP_INBAND   = 2'b11,
  parameter logic [1:0]  CAP_CFAULT   = 2'b11,
  parameter logic [1:0]  CAP_DREC     = 2'b11,
  parameter logic [1:0]  CAP_CRIT     = 2'b10,
  parameter bit          HAS_COUNTERS = 1'b1,
  parameter bit          REPORT_RST   = 1'b0,
  parameter logic [13:0] CTRL_RST     = 14'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             evt_valid,
  input  logic [1:0]       evt_class,
  input  logic             evt_write,
  input  logic             evt_nodefer,
  input  logic             ovf_valid,
  input  logic             ovf_write,
  input  logic             irq_clr,
  output logic             irq_fault,
  output logic             irq_recov,
  output logic             irq_crit,
  output logic             abort_o
);
  import errctl_pkg::*;

  localparam logic [NFEAT-1:0][1:0] FEAT_CAPS =
    {CAP_DREC, CAP_CFAULT, CAP_INBAND, CAP_FAULT, CAP_UREC};
  localparam logic [CTRL_W-1:0] MASK = ctrl_mask(CAP_REPORT, CAP_CRIT, FEAT_CAPS);
  localparam logic [CTRL_W-1:0] RST_VAL =
    {CTRL_RST[CTRL_W-1:1], REPORT_RST};
  localparam bit CFAULT_IMPL = (CAP_CFAULT == CAP_SHARED) || (CAP_CFAULT == CAP_SPLIT);

  logic [CTRL_W-1:0] ctrl_q;
  logic [NFEAT-1:0]  en_evt, en_ovf;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^reg_wdata[REG_W-1:CTRL_W];

  errctl_regs #(.W(CTRL_W), .MASK(MASK), .RST_VAL(RST_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we),
    .wdata(reg_wdata[CTRL_W-1:0]), .ctrl_q(ctrl_q)
  );

  assign reg_rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};

  // per-feature enable resolved for the event direction and the overflow direction
  for (genvar f = 0; f < NFEAT; f++) begin : g_feat
    errctl_dirsel #(.CAP(FEAT_CAPS[f])) u_evt (
      .lo(ctrl_q[feat_lo(f)]), .hi(ctrl_q[feat_hi(f)]),
      .is_write(evt_write), .en(en_evt[f])
    );
    errctl_dirsel #(.CAP(FEAT_CAPS[f])) u_ovf (
      .lo(ctrl_q[feat_lo(f)]), .hi(ctrl_q[feat_hi(f)]),
      .is_write(ovf_write), .en(en_ovf[f])
    );
  end

  logic rep_on, crit_en, crit_hit, as_unc, is_def, is_corr, nodefer_eff;
  logic cfe_evt, cfe_ovf, corr_fault;
  logic set_fault, set_recov, set_crit;

  always_comb begin
    rep_on      = (CAP_REPORT == CAP_SHARED) ? ctrl_q[B_REPORT] : 1'b1;
    crit_en     = (CAP_CRIT == CAP_SHARED) && ctrl_q[B_CRIT];
    crit_hit    = evt_valid && (evt_class == CLS_CRIT) && crit_en;
    // a critical error with its interrupt disabled is an uncontained uncorrected error
    as_unc      = evt_valid && ((evt_class == CLS_UNC) ||
                                ((evt_class == CLS_CRIT) && !crit_en));
    nodefer_eff = evt_nodefer || (evt_class == CLS_CRIT);
    is_def      = evt_valid && (evt_class == CLS_DEF);
    is_corr     = evt_valid && (evt_class == CLS_CORR);

    cfe_evt     = CFAULT_IMPL ? en_evt[F_CFAULT] : en_evt[F_FAULT];
    cfe_ovf     = CFAULT_IMPL ? en_ovf[F_CFAULT] : en_ovf[F_FAULT];
    corr_fault  = HAS_COUNTERS ? (ovf_valid && cfe_ovf) : (is_corr && cfe_evt);

    set_fault   = rep_on && ((((is_def || as_unc) && en_evt[F_FAULT])) || corr_fault);
    set_recov   = rep_on && ((as_unc && en_evt[F_UREC]) || (is_def && en_evt[F_DREC]));
    set_crit    = rep_on && crit_hit;
    abort_o     = rep_on && as_unc && nodefer_eff && en_evt[F_INBAND];
  end

  logic [2:0] irq_set, irq_q;
  assign irq_set = {set_crit, set_recov, set_fault};

  for (genvar i = 0; i < 3; i++) begin : g_irq
    errctl_irq_flag u_flag (
      .clk(clk), .rst_n(rst_n), .rec_rst_n(rec_rst_n),
      .set(irq_set[i]), .clr(irq_clr), .q(irq_q[i])
    );
  end

  assign irq_fault = irq_q[0];
  assign irq_recov = irq_q[1];
  assign irq_crit  = irq_q[2];
endmodule

// File: rtl/errctl_sig_chk.sv
module errctl_sig_chk #(
  parameter int REG_W       = 64,
  parameter bit REPORT_IMPL = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rec_rst_n,
  input logic             reg_we,
  input logic [REG_W-1:0] reg_rdata,
  input logic             evt_valid,
  input logic [1:0]       evt_class,
  input logic             ovf_valid,
  input logic             irq_clr,
  input logic             irq_fault,
  input logic             irq_recov,
  input logic             irq_crit,
  input logic             abort_o
);
  a_r1_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[REG_W-1:14] == '0) && !reg_rdata[12] && !reg_rdata[1]);

  a_r3_quiet_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (REPORT_IMPL && !reg_rdata[0]) |-> !abort_o);

  a_r3_quiet_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (REPORT_IMPL && !reg_rdata[0] && !irq_fault) |=> !irq_fault);

  a_r8_abort_class: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (evt_valid && (evt_class[1] == 1'b1)));

  a_r9_crit_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_crit) |-> $past(evt_valid && (evt_class == 2'd3)));

  a_r10_hold_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_fault && !irq_clr && rec_rst_n) |=> irq_fault);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !evt_valid && !ovf_valid) |=> (!irq_fault && !irq_recov && !irq_crit));

  a_r11_keep_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_rst_n && !reg_we) |=> (reg_rdata == $past(reg_rdata)));
endmodule

bind errctl_sig errctl_sig_chk #(
  .REG_W(REG_W), .REPORT_IMPL(CAP_REPORT == 2'b10)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rec_rst_n(rec_rst_n), .reg_we(reg_we),
  .reg_rdata(reg_rdata), .evt_valid(evt_valid), .evt_class(evt_class),
  .ovf_valid(ovf_valid), .irq_clr(irq_clr), .irq_fault(irq_fault),
  .irq_recov(irq_recov), .irq_crit(irq_crit), .abort_o(abort_o)
);

// File: tb/errctl_sig_tb.sv
module errctl_sig_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0, rec_rst_n = 1'b1, reg_we = 1'b0, irq_clr = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic evt_valid = 1'b0, evt_write = 1'b0, evt_nodefer = 1'b0;
  logic [1:0] evt_class = 2'd0;
  logic ovf_valid = 1'b0, ovf_write = 1'b0;

  logic [63:0] rdata_a, rdata_b;
  logic f_a, r_a, c_a, ab_a, f_b, r_b, c_b, ab_b;
  logic ab_a_s, ab_b_s;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // split controls, with counters
  errctl_sig u_dut (
    .clk(clk), .rst_n(rst_n), .rec_rst_n(rec_rst_n), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_a), .evt_valid(evt_valid),
    .evt_class(evt_class), .evt_write(evt_write), .evt_nodefer(evt_nodefer),
    .ovf_valid(ovf_valid), .ovf_write(ovf_write), .irq_clr(irq_clr),
    .irq_fault(f_a), .irq_recov(r_a), .irq_crit(c_a), .abort_o(ab_a)
  );

  // shared controls, no corrected-fault control, no in-band, no critical, no counters
  errctl_sig #(
    .CAP_UREC(2'b10), .CAP_FAULT(2'b10), .CAP_INBAND(2'b00), .CAP_CFAULT(2'b00),
    .CAP_DREC(2'b10), .CAP_CRIT(2'b00), .HAS_COUNTERS(1'b0),
    .REPORT_RST(1'b1), .CTRL_RST(14'h3FFF)
  ) u_dut_b (
    .clk(clk), .rst_n(rst_n), .rec_rst_n(rec_rst_n), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .evt_valid(evt_valid),
    .evt_class(evt_class), .evt_write(evt_write), .evt_nodefer(evt_nodefer),
    .ovf_valid(ovf_valid), .ovf_write(ovf_write), .irq_clr(irq_clr),
    .irq_fault(f_b), .irq_recov(r_b), .irq_crit(c_b), .abort_o(ab_b)
  );

  // {ctrl[13:0], class[1:0], write, nodefer, use_ovf, exp{abort,fault,recov,crit}}
  localparam logic [22:0] VEC [NV] = '{
    {14'h2FFC, 2'd2, 1'b0, 1'b1, 1'b0, 4'b0000},
    {14'h2FFD, 2'd2, 1'b0, 1'b1, 1'b0, 4'b1110},
    {14'h0011, 2'd2, 1'b1, 1'b1, 1'b0, 4'b0000},
    {14'h0081, 2'd2, 1'b1, 1'b1, 1'b0, 4'b1000},
    {14'h0081, 2'd2, 1'b1, 1'b0, 1'b0, 4'b0000},
    {14'h0009, 2'd1, 1'b0, 1'b0, 1'b0, 4'b0100},
    {14'h0401, 2'd1, 1'b0, 1'b0, 1'b0, 4'b0010},
    {14'h0801, 2'd1, 1'b1, 1'b0, 1'b0, 4'b0010},
    {14'h0401, 2'd1, 1'b1, 1'b0, 1'b0, 4'b0000},
    {14'h0021, 2'd2, 1'b1, 1'b0, 1'b0, 4'b0010},
    {14'h0005, 2'd2, 1'b1, 1'b0, 1'b0, 4'b0000},
    {14'h2001, 2'd3, 1'b0, 1'b0, 1'b0, 4'b0001},
    {14'h0005, 2'd3, 1'b0, 1'b0, 1'b0, 4'b0010},
    {14'h0015, 2'd3, 1'b0, 1'b0, 1'b0, 4'b1010},
    {14'h2015, 2'd3, 1'b0, 1'b0, 1'b0, 4'b0001},
    {14'h0101, 2'd0, 1'b0, 1'b0, 1'b0, 4'b0000},
    {14'h0101, 2'd0, 1'b0, 1'b0, 1'b1, 4'b0100},
    {14'h0201, 2'd0, 1'b1, 1'b0, 1'b1, 4'b0100},
    {14'h0101, 2'd0, 1'b1, 1'b0, 1'b1, 4'b0000},
    {14'h0041, 2'd1, 1'b1, 1'b0, 1'b0, 4'b0100},
    {14'h2FFC, 2'd0, 1'b0, 1'b0, 1'b1, 4'b0000},
    {14'h0009, 2'd0, 1'b0, 1'b0, 1'b0, 4'b0000}
  };
  localparam string TAG [NV] = '{
    "R3", "R5/R7/R8 rd", "R4 rd-only inband", "R4/R8 wr inband", "R8 deferrable",
    "R5 def rd", "R7 def rd", "R4 def wr", "R4 def wr off", "R7 unc wr",
    "R4 unc wr off", "R9 crit on", "R9 crit as unc", "R9 crit abort", "R9 crit only",
    "R6 corr evt w/ counters", "R6 ovf rd", "R6 ovf wr", "R6 ovf wr off", "R5 def wr",
    "R3 ovf", "R6 fault no corr"
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_ctrl(input logic [13:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = {50'b0, v}; irq_clr = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; irq_clr = 1'b0;
  endtask

  // drive one event or overflow for a cycle; abort sampled in that cycle,
  // return at the next falling edge where the interrupts are due
  task automatic fire(input logic [1:0] cls, input logic wr, input logic nd, input logic ov);
    if (ov) begin ovf_valid = 1'b1; ovf_write = wr; end
    else begin evt_valid = 1'b1; evt_class = cls; evt_write = wr; evt_nodefer = nd; end
    #1;
    ab_a_s = ab_a; ab_b_s = ab_b;
    @(negedge clk);
    evt_valid = 1'b0; ovf_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2 ctrl a", rdata_a, 64'h0);
    check("R2 ctrl b", rdata_b, 64'h040D);
    check("R2 irqs", {61'b0, f_a, r_a, c_a}, 64'h0);
    rst_n = 1'b1;
    // R1 write all ones
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = '1;
    @(negedge clk);
    reg_we = 1'b0;
    check("R1 mask a", rdata_a, 64'h2FFD);
    check("R1 mask b", rdata_b, 64'h040D);
    // second instance: shared controls, no counters, no corrected-fault control
    fire(2'd0, 1'b1, 1'b0, 1'b0);
    check("R6 fallback b", {63'b0, f_b}, 64'h1);
    set_ctrl(14'h3FFF);
    fire(2'd2, 1'b1, 1'b1, 1'b0);
    check("R8 abort absent b", {63'b0, ab_b_s}, 64'h0);
    check("R4 shared wr recov b", {63'b0, r_b}, 64'h1);
    set_ctrl(14'h3FFF);
    fire(2'd3, 1'b0, 1'b0, 1'b0);
    check("R9 no crit ctrl b", {62'b0, c_b, r_b}, 64'h1);
    // R10 level hold and clear
    set_ctrl(14'h2FFD);
    fire(2'd2, 1'b0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check("R10 hold", {62'b0, f_a, r_a}, 64'h3);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check("R10 cleared", {62'b0, f_a, r_a}, 64'h0);
    // R10 set wins over clear
    irq_clr = 1'b1;
    fire(2'd2, 1'b0, 1'b1, 1'b0);
    irq_clr = 1'b0;
    check("R10 set wins", {63'b0, f_a}, 64'h1);
    // R11 recovery reset
    rec_rst_n = 1'b0;
    @(negedge clk);
    rec_rst_n = 1'b1;
    check("R11 ctrl kept", rdata_a, 64'h2FFD);
    check("R11 irq cleared", {62'b0, f_a, r_a}, 64'h0);
    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      set_ctrl(v[22:9]);
      fire(v[8:7], v[6], v[5], v[4]);
      check(TAG[i], {60'b0, ab_a_s, f_a, r_a, c_a}, {60'b0, v[3:0]});
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule